// File: doc/BRIEF.md
# Endian-Aware Store Merge Unit

This block takes a single store request at a time and commits it to a synchronous single-port memory organised as 32-bit words. Each request carries a real address, a three-bit length code, a byte-order flag (little-endian when set), a starting byte offset into a 256-bit data bus, the bus itself, a 32-bit byte-enable mask and a data-valid flag. The unit decodes the length code, finds the target word, and either merges one byte or one halfword into the existing word through a read-modify-write, or writes one or more full words back to back.

For stores of two or more words, the byte-order flag sets the address direction. In little-endian order the first data word goes to the lowest address and the rest follow upward. In big-endian order the first data word goes to the highest address and the rest follow downward. A request that cannot be performed is acknowledged with an error flag and touches no memory. The unit stays busy while it works and pulses a one-cycle pop when it has finished, so a requester can issue the next store as soon as busy falls.

Top module: `store_merge_unit`

## Requirements
- R1: Length codes decode as follows: code 1 is one byte, code 2 is two bytes, code 4 is four bytes, code 5 is eight bytes, code 6 is sixteen bytes and code 7 is thirty-two bytes. A store of four or more bytes issues length/4 word writes, and each write carries all 32 bits.
- R2: Length codes 0 and 3 are illegal. The request is acknowledged by pop and err together in the cycle after acceptance, and no memory access (mem_en) takes place.
- R3: A request with req_dvalid low, or with req_be equal to zero, gets the same error acknowledgement as R2 and causes no memory access. For a legal request the byte-enable value has no other effect.
- R4: The target word address is computed in three steps: clear address bits [3:0], add the start offset, then drop bits [1:0]. The result is truncated to the memory address width.
- R5: A one-byte store reads the target word in its first busy cycle and writes it back in the second. Exactly one byte changes. With le set, that byte sits at bits [8*a+7:8*a], where a is address bits [1:0]. With le clear, it sits at bits [8*(3-a)+7:8*(3-a)].
- R6: A two-byte store uses the same read-then-write sequence. Let h be address bit 1. With le set, the halfword lands at bits [16*h+15:16*h]. With le clear, it lands at bits [16*(1-h)+15:16*(1-h)]. The other halfword keeps its value.
- R7: A four-byte store makes a single write with no read, in the cycle after acceptance.
- R8: Stores of 8, 16 and 32 bytes write one word per cycle on consecutive cycles. When le is set, data word j goes to the base address plus j. When le is clear, it goes to the base address plus N-1-j.
- R9: Bus byte k is req_data[255-8k:248-8k], and a data word takes four consecutive bus bytes, with the first byte most significant. Byte, halfword and 8-byte stores read their data starting at bus byte req_start. Stores of 16 and 32 bytes read theirs from bus byte 0.
- R10: A request is accepted on a rising edge where req_valid is high and busy is low. From that edge on, busy stays high until the end of the cycle in which pop is high. Pop lasts exactly one cycle and follows the final write, or comes directly after acceptance for an error.
- R11: While busy is high, req_valid and the request fields are ignored. The sequence already in progress finishes unchanged, and no new sequence starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Store request present |
| req_addr | input | 32 | Real byte address |
| req_len | input | 3 | Length code |
| req_le | input | 1 | 1 = little-endian, 0 = big-endian |
| req_start | input | 5 | Start byte offset within the bus |
| req_data | input | 256 | Store data bus, byte 0 in the top bits |
| req_be | input | 32 | Byte-enable mask (all zero = missing) |
| req_dvalid | input | 1 | Data and enables are valid |
| busy | output | 1 | A request is in progress |
| pop | output | 1 | One-cycle completion acknowledge |
| err | output | 1 | Error qualifier, high only together with pop |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (0 = read) |
| mem_addr | output | 10 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |

## Verification
The hardest case to reach from the ports is a request that arrives while a long sequence is already running. The stimulus holds req_valid high with unrelated fields through every cycle of a 32-byte big-endian store, up to and including the pop cycle. It then checks that each beat keeps its address and data and that no second sequence starts. The read-modify-write path is driven through all four byte lanes and both halfwords in both byte orders. This is done on words whose old contents differ in every byte, so that any disturbed neighbouring byte shows up in the full memory comparison.

// File: rtl/stmerge_pkg.sv
package stmerge_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_MERGE,
        S_BEAT,
        S_DONE
    } sm_state_e;

    typedef struct packed {
        logic       legal;
        logic       sub;        // byte or halfword, needs read-modify-write
        logic       half;       // halfword when sub
        logic [3:0] nwords;     // full-word writes when not sub
        logic       from_zero;  // data taken from bus byte 0
    } len_info_t;

    function automatic len_info_t decode_len(input logic [2:0] code);
        len_info_t d;
        d = '0;
        case (code)
            3'd1: begin d.legal = 1'b1; d.sub = 1'b1; d.nwords = 4'd1; end
            3'd2: begin d.legal = 1'b1; d.sub = 1'b1; d.half = 1'b1; d.nwords = 4'd1; end
            3'd4: begin d.legal = 1'b1; d.nwords = 4'd1; end
            3'd5: begin d.legal = 1'b1; d.nwords = 4'd2; end
            3'd6: begin d.legal = 1'b1; d.nwords = 4'd4; d.from_zero = 1'b1; end
            3'd7: begin d.legal = 1'b1; d.nwords = 4'd8; d.from_zero = 1'b1; end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sm_req_decode.sv
module sm_req_decode
    import stmerge_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MEM_AW = 10,
    parameter int OFF_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        code,
    input  logic [OFF_W-1:0]  start,
    output len_info_t         info,
    output logic [MEM_AW-1:0] waddr
);
    logic [ADDR_W-1:0] byte_base;

    always_comb begin
        info      = decode_len(code);
        byte_base = {addr[ADDR_W-1:4], 4'b0000} + ADDR_W'(start);
        waddr     = byte_base[MEM_AW+1:2];
    end
endmodule

// File: rtl/sm_bus_pick.sv
module sm_bus_pick #(
    parameter int BUS_BYTES = 32,
    parameter int OFF_W     = 6
) (
    input  logic [8*BUS_BYTES-1:0] bus,
    input  logic [OFF_W-1:0]       offset,
    output logic [31:0]            word
);
    localparam int BUS_W = 8 * BUS_BYTES;

    logic [BUS_W-1:0]   shifted;
    logic [OFF_W+2:0]   shamt;

    always_comb begin
        shamt   = {offset, 3'b000};
        shifted = bus << shamt;
        word    = shifted[BUS_W-1 -: 32];
    end
endmodule

// File: rtl/sm_lane_merge.sv
module sm_lane_merge (
    input  logic [31:0] old_word,
    input  logic [31:0] src,      // byte in [31:24], halfword in [31:16]
    input  logic        half,
    input  logic        le,
    input  logic [1:0]  lane,
    output logic [31:0] merged
);
    logic [1:0] bpos;
    logic       hpos;

    always_comb begin
        merged = old_word;
        bpos   = le ? lane : (2'd3 - lane);
        hpos   = le ? lane[1] : ~lane[1];
        if (half) begin
            merged[16*hpos +: 16] = src[31:16];
        end else begin
            merged[8*bpos +: 8]   = src[31:24];
        end
    end
endmodule

// File: rtl/store_merge_unit.sv
module store_merge_unit
    import stmerge_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MEM_AW    = 10,
    parameter int BUS_BYTES = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [2:0]             req_len,
    input  logic                   req_le,
    input  logic [$clog2(BUS_BYTES)-1:0] req_start,
    input  logic [8*BUS_BYTES-1:0] req_data,
    input  logic [BUS_BYTES-1:0]   req_be,
    input  logic                   req_dvalid,
    output logic                   busy,
    output logic                   pop,
    output logic                   err,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [MEM_AW-1:0]      mem_addr,
    output logic [31:0]            mem_wdata,
    input  logic [31:0]            mem_rdata
);
    localparam int OFF_W  = $clog2(BUS_BYTES);
    localparam int PICK_W = OFF_W + 1;
    localparam int BUS_W  = 8 * BUS_BYTES;

    sm_state_e          st;
    logic [MEM_AW-1:0]  r_wbase;
    logic [3:0]         r_n;
    logic [2:0]         r_idx;
    logic               r_le;
    logic               r_half;
    logic [1:0]         r_lane;
    logic [OFF_W-1:0]   r_src;
    logic [BUS_W-1:0]   r_data;
    logic               r_err;

    len_info_t          d_info;
    logic [MEM_AW-1:0]  d_waddr;
    logic               d_bad;

    sm_req_decode #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .OFF_W(OFF_W)) u_dec (
        .addr  (req_addr),
        .code  (req_len),
        .start (req_start),
        .info  (d_info),
        .waddr (d_waddr)
    );

    assign d_bad = !d_info.legal || !req_dvalid || (req_be == '0);

    logic [PICK_W-1:0] pick_off;
    logic [31:0]       pick_word;
    logic [31:0]       merge_word;
    logic              last_beat;
    logic [MEM_AW-1:0] beat_addr;

    assign pick_off  = PICK_W'(r_src) + PICK_W'({r_idx, 2'b00});
    assign last_beat = ({1'b0, r_idx} == (r_n - 4'd1));
    assign beat_addr = r_le ? (r_wbase + MEM_AW'(r_idx))
                            : (r_wbase + MEM_AW'(r_n - 4'd1 - {1'b0, r_idx}));

    sm_bus_pick #(.BUS_BYTES(BUS_BYTES), .OFF_W(PICK_W)) u_pick (
        .bus    (r_data),
        .offset (pick_off),
        .word   (pick_word)
    );

    sm_lane_merge u_merge (
        .old_word (mem_rdata),
        .src      (pick_word),
        .half     (r_half),
        .le       (r_le),
        .lane     (r_lane),
        .merged   (merge_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            r_wbase <= '0;
            r_n     <= '0;
            r_idx   <= '0;
            r_le    <= 1'b0;
            r_half  <= 1'b0;
            r_lane  <= '0;
            r_src   <= '0;
            r_data  <= '0;
            r_err   <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        r_wbase <= d_waddr;
                        r_n     <= d_info.nwords;
                        r_idx   <= '0;
                        r_le    <= req_le;
                        r_half  <= d_info.half;
                        r_lane  <= req_addr[1:0];
                        r_src   <= d_info.from_zero ? '0 : req_start;
                        r_data  <= req_data;
                        r_err   <= d_bad;
                        if (d_bad)             st <= S_DONE;
                        else if (d_info.sub)   st <= S_READ;
                        else                   st <= S_BEAT;
                    end
                end
                S_READ:  st <= S_MERGE;
                S_MERGE: st <= S_DONE;
                S_BEAT: begin
                    if (last_beat) st <= S_DONE;
                    else           r_idx <= r_idx + 3'd1;
                end
                S_DONE: begin
                    st    <= S_IDLE;
                    r_err <= 1'b0;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (st != S_IDLE);
        pop       = (st == S_DONE);
        err       = (st == S_DONE) && r_err;
        mem_en    = (st == S_READ) || (st == S_MERGE) || (st == S_BEAT);
        mem_we    = (st == S_MERGE) || (st == S_BEAT);
        mem_addr  = (st == S_BEAT) ? beat_addr : r_wbase;
        mem_wdata = (st == S_MERGE) ? merge_word : pick_word;
    end

    // R10: pop is a single-cycle pulse
    p_pop_single_r10: assert property (@(posedge clk) disable iff (rst)
        pop |=> !pop);

    // R10: busy only falls right after a pop
    p_busy_ends_with_pop_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(pop));

    // R5 / R6: a merge write follows a read of the same word
    p_rmw_read_first_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_we && st == S_MERGE) |-> ($past(mem_en && !mem_we) && mem_addr == $past(mem_addr)));

    // R8: consecutive beats step by one word in the direction set by byte order
    p_beat_stride_r8: assert property (@(posedge clk) disable iff (rst)
        (st == S_BEAT && $past(st) == S_BEAT)
            |-> (mem_addr == (r_le ? $past(mem_addr) + MEM_AW'(1) : $past(mem_addr) - MEM_AW'(1))));

    // R2 / R3: an error acknowledge is preceded by no memory access
    p_err_no_access_r2: assert property (@(posedge clk) disable iff (rst)
        err |-> (pop && $past(!mem_en)));

    // R11: no memory activity while idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_en);

endmodule

// File: tb/store_merge_unit_bench.sv
module store_merge_unit_bench;
    localparam int MEM_WORDS = 1024;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [31:0]  req_addr;
    logic [2:0]   req_len;
    logic         req_le;
    logic [4:0]   req_start;
    logic [255:0] req_data;
    logic [31:0]  req_be;
    logic         req_dvalid;
    logic         busy, pop, err, mem_en, mem_we;
    logic [9:0]   mem_addr;
    logic [31:0]  mem_wdata;
    logic [31:0]  mem_rdata;

    logic [31:0]  mem    [0:MEM_WORDS-1];
    logic [31:0]  refmem [0:MEM_WORDS-1];

    int vectors = 0;
    int misses  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    store_merge_unit u_store_merge_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_le(req_le), .req_start(req_start),
        .req_data(req_data), .req_be(req_be), .req_dvalid(req_dvalid),
        .busy(busy), .pop(pop), .err(err), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // synchronous single-port word memory
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end

    function automatic logic [7:0] bb(input logic [255:0] d, input int k);
        if (k < 0 || k > 31) return 8'h00;
        return d[255 - 8*k -: 8];
    endfunction

    function automatic logic [31:0] bw(input logic [255:0] d, input int k);
        return {bb(d, k), bb(d, k+1), bb(d, k+2), bb(d, k+3)};
    endfunction

    function automatic logic [255:0] pattern(input int seed);
        logic [255:0] d;
        for (int k = 0; k < 32; k++) d[255 - 8*k -: 8] = 8'(seed + 13*k + 1);
        return d;
    endfunction

    task automatic check(input string req, input logic en, input logic we,
                         input logic [9:0] a, input logic [31:0] wd,
                         input logic p, input logic e, input logic b);
        bit bad;
        vectors++;
        bad = (mem_en !== en) || (mem_we !== we) || (pop !== p) || (err !== e) || (busy !== b);
        if (en && mem_addr !== a) bad = 1'b1;
        if (we && mem_wdata !== wd) bad = 1'b1;
        if (bad) begin
            misses++;
            $display("FAIL %s: act en=%b we=%b addr=%h wd=%h pop=%b err=%b busy=%b exp en=%b we=%b addr=%h wd=%h pop=%b err=%b busy=%b",
                     req, mem_en, mem_we, mem_addr, mem_wdata, pop, err, busy, en, we, a, wd, p, e, b);
        end
    endtask

    task automatic compare_mem(input string req);
        int diffs = 0;
        int first = -1;
        vectors++;
        for (int i = 0; i < MEM_WORDS; i++)
            if (mem[i] !== refmem[i]) begin
                diffs++;
                if (first < 0) first = i;
            end
        if (diffs != 0) begin
            misses++;
            $display("FAIL %s: memory word %0d act=%h exp=%h (%0d words differ)",
                     req, first, mem[first], refmem[first], diffs);
        end
    endtask

    // drive one request at a negedge and follow it cycle by cycle
    task automatic run_req(input string req, input logic [31:0] addr, input logic [2:0] code,
                           input logic le, input int start, input logic [255:0] data,
                           input logic [31:0] be, input logic dv, input bit intrude);
        logic [9:0]  wa;
        logic [31:0] old_w, new_w, w;
        logic [9:0]  a;
        int n, src, pos;
        req_valid = 1'b1; req_addr = addr; req_len = code; req_le = le;
        req_start = 5'(start); req_data = data; req_be = be; req_dvalid = dv;
        wa = 10'((((addr & 32'hFFFF_FFF0) + 32'(start)) >> 2));
        @(posedge clk);
        @(negedge clk);
        if (intrude) begin
            req_addr = 32'h0000_0100; req_len = 3'd4; req_le = ~le;
            req_data = pattern(99); req_be = 32'hFFFF_FFFF; req_dvalid = 1'b1;
        end else begin
            req_valid = 1'b0;
        end
        if (code == 3'd0 || code == 3'd3 || !dv || be == 32'h0) begin
            check({req, " R2/R3 error ack"}, 1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 1'b1);
        end else if (code == 3'd1 || code == 3'd2) begin
            old_w = refmem[wa];
            new_w = old_w;
            if (code == 3'd1) begin
                pos = le ? int'(addr[1:0]) : 3 - int'(addr[1:0]);
                new_w[8*pos +: 8] = bb(data, start);
            end else begin
                pos = le ? int'(addr[1]) : 1 - int'(addr[1]);
                new_w[16*pos +: 16] = {bb(data, start), bb(data, start+1)};
            end
            check({req, " R5/R6 read"}, 1'b1, 1'b0, wa, '0, 1'b0, 1'b0, 1'b1);
            @(negedge clk);
            check({req, " R5/R6 merged write R9"}, 1'b1, 1'b1, wa, new_w, 1'b0, 1'b0, 1'b1);
            refmem[wa] = new_w;
            @(negedge clk);
            check({req, " R10 pop"}, 1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 1'b1);
        end else begin
            n   = (code == 3'd4) ? 1 : (code == 3'd5) ? 2 : (code == 3'd6) ? 4 : 8;
            src = (code >= 3'd6) ? 0 : start;
            for (int j = 0; j < n; j++) begin
                a = le ? 10'(wa + 10'(j)) : 10'(wa + 10'(n - 1 - j));
                w = bw(data, src + 4*j);
                check({req, " R1/R7/R8/R9 beat"}, 1'b1, 1'b1, a, w, 1'b0, 1'b0, 1'b1);
                refmem[a] = w;
                @(negedge clk);
            end
            check({req, " R10 pop"}, 1'b0, 1'b0, '0, '0, 1'b1, 1'b0, 1'b1);
        end
        req_valid = 1'b0;
        @(negedge clk);
        check({req, " R10/R11 idle after pop"}, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        compare_mem({req, " R4 memory image"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) begin
            mem[i]    = 32'h1122_3344 ^ (32'(i) * 32'h0101_0101);
            refmem[i] = mem[i];
        end
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_len = '0; req_le = 1'b0;
        req_start = '0; req_data = '0; req_be = '0; req_dvalid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset state", 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);

        // R5: every byte lane, both orders
        for (int le = 0; le < 2; le++)
            for (int b = 0; b < 4; b++)
                run_req("R5 byte", 32'h0000_0040 + 32'(b), 3'd1, 1'(le), 4*b + 3,
                        pattern(b + 10*le), 32'h1, 1'b1, 1'b0);
        // R6: both halfwords, both orders
        for (int le = 0; le < 2; le++)
            for (int h = 0; h < 2; h++)
                run_req("R6 half", 32'h0000_0080 + 32'(2*h), 3'd2, 1'(le), 6 + h,
                        pattern(40 + h + 2*le), 32'h3, 1'b1, 1'b0);
        // R7 and R4: low address bits cleared, offset added
        run_req("R7 R4 word", 32'h0000_1237, 3'd4, 1'b0, 20, pattern(60), 32'hF, 1'b1, 1'b0);
        // R8 / R9: multi-word stores
        run_req("R8 dword le", 32'h0000_0200, 3'd5, 1'b1, 8, pattern(70), 32'hFF, 1'b1, 1'b0);
        run_req("R8 dword be", 32'h0000_0210, 3'd5, 1'b0, 8, pattern(71), 32'hFF, 1'b1, 1'b0);
        run_req("R9 quad le", 32'h0000_0300, 3'd6, 1'b1, 4, pattern(72), 32'hFFFF, 1'b1, 1'b0);
        run_req("R9 quad be", 32'h0000_0340, 3'd6, 1'b0, 4, pattern(73), 32'hFFFF, 1'b1, 1'b0);
        run_req("R1 oct le", 32'h0000_0400, 3'd7, 1'b1, 0, pattern(74), 32'hFFFF_FFFF, 1'b1, 1'b0);
        run_req("R1 oct be", 32'h0000_0480, 3'd7, 1'b0, 0, pattern(75), 32'hFFFF_FFFF, 1'b1, 1'b0);
        // R2 / R3: error cases
        run_req("R2 code0", 32'h0000_0500, 3'd0, 1'b1, 0, pattern(80), 32'hF, 1'b1, 1'b0);
        run_req("R2 code3", 32'h0000_0500, 3'd3, 1'b0, 0, pattern(81), 32'hF, 1'b1, 1'b0);
        run_req("R3 no data", 32'h0000_0500, 3'd4, 1'b1, 0, pattern(82), 32'hF, 1'b0, 1'b0);
        run_req("R3 no enables", 32'h0000_0500, 3'd5, 1'b0, 0, pattern(83), 32'h0, 1'b1, 1'b0);
        // R11: request held high through a whole big-endian 32-byte sequence
        run_req("R11 intrude", 32'h0000_0600, 3'd7, 1'b0, 0, pattern(90), 32'hFFFF_FFFF, 1'b1, 1'b1);
        // back to back after the intrusion
        run_req("R5 byte after", 32'h0000_0603, 3'd1, 1'b0, 31, pattern(91), 32'h1, 1'b1, 1'b0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule